// File: doc/BRIEF.md
# Mode-Filtered Event Counter Bank

This block holds up to four pairs of 32-bit registers, each pair being a control word and an event counter, for use beside a processor pipeline. The pipeline supplies one pulse line per implemented event, the current privilege level, an exception-level flag, and the identifiers of the running hardware thread and virtual processor. A counter advances by one on a cycle where its selected event pulses, but only if the active mode is enabled in its control word and the optional thread or virtual-processor filter matches.

Software sees the bank through a small register port. Writes take effect at the next clock edge. Reads return data one cycle later, flagged by a valid strobe. To profile every N events, software presets a counter to 0x80000000 minus N and sets the interrupt enable. Once bit 31 of the counter is set, a level interrupt is raised. Software finds which counter caused it, services it, and rewrites the preset value, which drops the request. A capability word shows that counters exist. Each control word carries a read-only "more" flag, so software can find out how many pairs are present by walking through them.

Top module: `mfec_bank`

## Requirements
- R1: After synchronous active-low reset, every control field and every counter reads 0 and `irq` is low.
- R2: The address map uses bit 3 = 0 for pairs: bits 2:1 give the pair index, and bit 0 selects 0 = control, 1 = counter. Control bits 30:16 and 14:0 can be written. Bit 15 always reads 0. Bit 31 is read-only and reads 1 on every pair except the last implemented one.
- R3: Mode filter. Control bit 0 enables counting at exception level, bit 1 in kernel (`priv`=0), bit 2 in supervisor (`priv`=1) and bit 3 in user (`priv`=2). When `exl` is high, only bit 0 is consulted, whatever the value of `priv`.
- R4: Thread filter. Control bits 21:20 select the mode: 0 counts for all threads, 1 requires bits 19:16 to equal `cur_vpe`, and 2 requires bits 29:22 to equal `cur_tc`. Value 3 never counts.
- R5: Control bits 14:5 select the event line. A counter advances only when that line pulses. A select code at or above NUM_EVT never counts, and a control word of zero stops counting.
- R6: Counters can be read and written. They keep counting after bit 31 is set and wrap from 0xFFFFFFFF to 0.
- R7: `irq` is high exactly while some counter has bit 31 set and its control bit 4 set. Rewriting that counter with a value whose bit 31 is clear, or clearing bit 4, drops the request.
- R8: Address 8 reads as a capability word with bit 4 = 1. Address 9 reads as a status word whose bit 26 equals `irq`. Writes to either address are ignored.
- R9: A software write to a counter in the same cycle as a qualifying event loads the written value, and the increment is dropped.
- R10: `reg_rvalid` is high in the cycle after `reg_rd`, and `reg_rdata` then holds the value addressed in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid |
| evt_pulse | input | NUM_EVT | One pulse line per event code |
| priv | input | 2 | Privilege: 0 kernel, 1 supervisor, 2 user |
| exl | input | 1 | Exception level active |
| cur_vpe | input | 4 | Running virtual-processor ID |
| cur_tc | input | 8 | Running hardware thread ID |
| irq | output | 1 | Level counter interrupt |

## Verification
The counters are driven with single event pulses under each combination of privilege and exception level. Only the mode whose enable bit is set may move a counter, and an active exception level must mask user mode. A separate pattern pulses every event line at once with an out-of-range select code, which shows that the select decode counts nothing it should not. Matching and mismatching thread and virtual-processor IDs separate the two filter modes. Presets just below 0x80000000 and at 0xFFFFFFFF test the interrupt edge, the drop on rewrite, the effect of the enable bit, and wrap-around. A write to a counter in the same cycle as an event shows which of the two wins.

// File: rtl/mfec_pkg.sv
// Package: shared field positions and encodings for the event counter bank.
// Assumes 32-bit registers; field positions are fixed by the control format.
package mfec_pkg;
    localparam int REG_W      = 32;
    localparam int SEL_W      = 10;
    localparam int VPE_W      = 4;
    localparam int TC_W       = 8;
    localparam int B_EXL      = 0;
    localparam int B_KERN     = 1;
    localparam int B_SUP      = 2;
    localparam int B_USR      = 3;
    localparam int B_IE       = 4;
    localparam int SEL_LO     = 5;
    localparam int VPE_LO     = 16;
    localparam int TMODE_LO   = 20;
    localparam int TC_LO      = 22;
    localparam int B_MORE     = 31;
    localparam int STAT_BIT   = 26;
    localparam int CAP_BIT    = 4;
    // Writable control bits: 30:16 and 14:0
    localparam logic [REG_W-1:0] CTL_WMASK = 32'h7FFF_7FFF;

    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'd0,
        PRIV_SUPER  = 2'd1,
        PRIV_USER   = 2'd2
    } priv_e;

    typedef enum logic [1:0] {
        TF_ALL = 2'd0,
        TF_VPE = 2'd1,
        TF_TC  = 2'd2
    } tfilt_e;
endpackage

// File: rtl/mfec_qualify.sv
// Module: mfec_qualify
// Decides, combinationally, whether this cycle counts for one counter.
// It combines three conditions: the selected event line pulses, the active
// mode is enabled, and the thread filter matches. Exception level takes
// priority over the privilege input. Assumes all inputs are stable before
// the clock edge.
module mfec_qualify
    import mfec_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input  logic [REG_W-1:0]   ctl,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [1:0]         priv,
    input  logic               exl,
    input  logic [VPE_W-1:0]   cur_vpe,
    input  logic [TC_W-1:0]    cur_tc,
    output logic               hit
);
    logic [SEL_W-1:0] sel;
    logic             mode_ok;
    logic             thr_ok;
    logic             evt_ok;

    assign sel = ctl[SEL_LO +: SEL_W];

    // Mode gate: exception level overrides the privilege level
    always_comb begin
        if (exl) begin
            mode_ok = ctl[B_EXL];
        end else begin
            case (priv_e'(priv))
                PRIV_KERNEL: mode_ok = ctl[B_KERN];
                PRIV_SUPER:  mode_ok = ctl[B_SUP];
                PRIV_USER:   mode_ok = ctl[B_USR];
                default:     mode_ok = 1'b0;
            endcase
        end
    end

    // Thread gate: all threads, a virtual-processor match, or a thread match
    always_comb begin
        case (tfilt_e'(ctl[TMODE_LO +: 2]))
            TF_ALL:  thr_ok = 1'b1;
            TF_VPE:  thr_ok = (ctl[VPE_LO +: VPE_W] == cur_vpe);
            TF_TC:   thr_ok = (ctl[TC_LO +: TC_W] == cur_tc);
            default: thr_ok = 1'b0;
        endcase
    end

    // Event select: codes with no event line never match
    always_comb begin
        evt_ok = 1'b0;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (sel == SEL_W'(e)) evt_ok = evt_pulse[e];
        end
    end

    assign hit = mode_ok & thr_ok & evt_ok;
endmodule

// File: rtl/mfec_slot.sv
// Module: mfec_slot
// One control/counter pair. The control word keeps only its writable bits,
// and bit 31 reads as the constant HAS_NEXT. The counter loads from software
// in preference to a qualifying increment, and it wraps at 2^32. The
// overflow request is bit 31 of the counter gated by the interrupt enable.
// Assumes at most one write strobe per cycle.
module mfec_slot
    import mfec_pkg::*;
#(
    parameter int NUM_EVT  = 16,
    parameter bit HAS_NEXT = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctl,
    input  logic               wr_cnt,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [1:0]         priv,
    input  logic               exl,
    input  logic [VPE_W-1:0]   cur_vpe,
    input  logic [TC_W-1:0]    cur_tc,
    output logic [REG_W-1:0]   ctl_o,
    output logic [REG_W-1:0]   cnt_o,
    output logic               ovf_req
);
    logic [REG_W-1:0] ctl_q;
    logic [REG_W-1:0] cnt_q;
    logic             hit;

    mfec_qualify #(.NUM_EVT(NUM_EVT)) u_qual (
        .ctl       (ctl_q),
        .evt_pulse (evt_pulse),
        .priv      (priv),
        .exl       (exl),
        .cur_vpe   (cur_vpe),
        .cur_tc    (cur_tc),
        .hit       (hit)
    );

    // Control register: stores the writable field bits only
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= wdata & CTL_WMASK;
    end

    // Counter: a software load wins over an increment in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= wdata;
        else if (hit)    cnt_q <= cnt_q + 1'b1;
    end

    assign ctl_o   = {HAS_NEXT, ctl_q[B_MORE-1:0]};
    assign cnt_o   = cnt_q;
    assign ovf_req = ctl_q[B_IE] & cnt_q[REG_W-1];

    // R9: a counter write always lands, whatever the events do
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt_o == $past(wdata));
    // R6: without a write the counter moves by at most one, wrapping
    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 32'd1));
    // R5: a zero control word freezes the counter
    assert_zero_ctl_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && ctl_o[B_MORE-1:0] == '0) |=> $stable(cnt_o));
    // R7: a preset with bit 31 clear drops this counter's request
    assert_preset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && !wdata[REG_W-1]) |=> !ovf_req);
endmodule

// File: rtl/mfec_bank.sv
// Module: mfec_bank (top)
// Bank of NUM_CTR event counter pairs behind a register port. It decodes
// the address, holds one registered read port, and combines the overflow
// requests into a level interrupt. Addresses 0..7 hold the pairs, 8 holds
// the capability word and 9 the status word. Assumes reg_wr and reg_rd are
// not used on the same address in the same cycle for ordering purposes; a
// read returns the value from before that cycle's write.
module mfec_bank
    import mfec_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [3:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               reg_rvalid,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [1:0]         priv,
    input  logic               exl,
    input  logic [3:0]         cur_vpe,
    input  logic [7:0]         cur_tc,
    output logic               irq
);
    localparam logic [3:0] ADDR_CAP  = 4'd8;
    localparam logic [3:0] ADDR_STAT = 4'd9;

    logic [REG_W-1:0] ctl_arr [NUM_CTR];
    logic [REG_W-1:0] cnt_arr [NUM_CTR];
    logic [NUM_CTR-1:0] req;
    logic [REG_W-1:0] rd_mux;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        logic sel_pair;
        assign sel_pair = !reg_addr[3] && (reg_addr[2:1] == 2'(i));
        mfec_slot #(
            .NUM_EVT  (NUM_EVT),
            .HAS_NEXT (i < NUM_CTR - 1)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctl    (reg_wr && sel_pair && !reg_addr[0]),
            .wr_cnt    (reg_wr && sel_pair &&  reg_addr[0]),
            .wdata     (reg_wdata),
            .evt_pulse (evt_pulse),
            .priv      (priv),
            .exl       (exl),
            .cur_vpe   (cur_vpe),
            .cur_tc    (cur_tc),
            .ctl_o     (ctl_arr[i]),
            .cnt_o     (cnt_arr[i]),
            .ovf_req   (req[i])
        );
    end

    assign irq = |req;

    // Read selection: pairs, capability, status; all else reads zero
    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_CAP) begin
            rd_mux[CAP_BIT] = 1'b1;
        end else if (reg_addr == ADDR_STAT) begin
            rd_mux[STAT_BIT] = irq;
        end else begin
            for (int i = 0; i < NUM_CTR; i++) begin
                if (!reg_addr[3] && reg_addr[2:1] == 2'(i))
                    rd_mux = reg_addr[0] ? cnt_arr[i] : ctl_arr[i];
            end
        end
    end

    // Registered read port with a one-cycle valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

    // R10: every read request is answered in the next cycle
    assert_read_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    // R8: a status read reports the interrupt level of the request cycle
    assert_status_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_STAT) |=> reg_rdata[STAT_BIT] == $past(irq));
    // R8: the capability word always shows counters present
    assert_cap_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_CAP) |=> reg_rdata[CAP_BIT]);
endmodule

// File: tb/mfec_bank_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push the expected words, and a monitor pops
// and compares them whenever the read strobe returns data.
module mfec_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [15:0] evt_pulse = '0;
    logic [1:0]  priv = 2'd0;
    logic        exl = 1'b0;
    logic [3:0]  cur_vpe = '0;
    logic [7:0]  cur_tc = '0;
    logic        irq;

    int total = 0;
    int fails = 0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    mfec_bank #(.NUM_CTR(4), .NUM_EVT(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .evt_pulse(evt_pulse), .priv(priv),
        .exl(exl), .cur_vpe(cur_vpe), .cur_tc(cur_tc), .irq(irq)
    );

    // Monitor: compare each returned read against the oldest expectation
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            item_t it;
            total++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R10: unexpected read data %h, expected none", reg_rdata);
            end else begin
                it = sb.pop_front();
                if (reg_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk);
        evt_pulse = m;
        @(posedge clk); #1;
        evt_pulse = '0;
    endtask

    task automatic wr_pulse(input logic [3:0] a, input logic [31:0] d, input logic [15:0] m);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; evt_pulse = m;
        @(posedge clk); #1;
        reg_wr = 1'b0; evt_pulse = '0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        total++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R2 / R8 reset view
        chk_irq(1'b0, "R1 irq after reset");
        rd(4'd0, 32'h8000_0000, "R1 ctl0 reset with more bit");
        rd(4'd6, 32'h0, "R2 last ctl has no more bit");
        rd(4'd1, 32'h0, "R1 cnt0 reset");
        rd(4'd8, 32'h10, "R8 capability word");
        rd(4'd9, 32'h0, "R8 status idle");
        // R2 write mask
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, 32'hFFFF_7FFF, "R2 control writable mask");
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd8, 32'h10, "R8 capability ignores writes");
        // R3 mode filter: user enable, event 2
        wr(4'd0, 32'h0000_0048);
        priv = 2'd2; exl = 1'b0;
        repeat (3) pulse(16'h0004);
        rd(4'd1, 32'd3, "R3 user mode counts");
        priv = 2'd0;
        pulse(16'h0004);
        rd(4'd1, 32'd3, "R3 kernel mode masked");
        priv = 2'd2; exl = 1'b1;
        pulse(16'h0004);
        rd(4'd1, 32'd3, "R3 exception level overrides user");
        exl = 1'b0;
        // R5 event select
        pulse(16'h0008);
        rd(4'd1, 32'd3, "R5 other event ignored");
        pulse(16'h0004);
        rd(4'd1, 32'd4, "R5 selected event counts");
        wr(4'd0, 32'h0);
        pulse(16'h0004);
        rd(4'd1, 32'd4, "R5 zero control stops");
        wr(4'd0, 32'h0000_0288);
        pulse(16'hFFFF);
        rd(4'd1, 32'd4, "R5 out-of-range select never counts");
        // R9 write beats increment
        wr(4'd0, 32'h0000_0048);
        wr_pulse(4'd1, 32'h0000_0100, 16'h0004);
        rd(4'd1, 32'h0000_0100, "R9 write wins over event");
        // R4 thread filters in kernel mode, event 5
        priv = 2'd0;
        wr(4'd2, 32'h0013_00A2);
        cur_vpe = 4'd3;
        pulse(16'h0020);
        rd(4'd3, 32'd1, "R4 vpe match counts");
        cur_vpe = 4'd2;
        pulse(16'h0020);
        rd(4'd3, 32'd1, "R4 vpe mismatch blocked");
        wr(4'd4, 32'h01E0_00A2);
        cur_tc = 8'd7;
        pulse(16'h0020);
        rd(4'd5, 32'd1, "R4 tc match counts");
        cur_tc = 8'd6;
        pulse(16'h0020);
        rd(4'd5, 32'd1, "R4 tc mismatch blocked");
        // R7 / R6 overflow and interrupt on pair 3, event 1
        wr(4'd7, 32'h7FFF_FFFE);
        wr(4'd6, 32'h0000_0032);
        pulse(16'h0002);
        chk_irq(1'b0, "R7 below bit 31 no irq");
        pulse(16'h0002);
        chk_irq(1'b1, "R7 bit 31 set raises irq");
        rd(4'd9, 32'h0400_0000, "R8 status shows pending");
        rd(4'd7, 32'h8000_0000, "R6 counter reached bit 31");
        pulse(16'h0002);
        rd(4'd7, 32'h8000_0001, "R6 keeps counting past bit 31");
        chk_irq(1'b1, "R7 irq is level");
        wr(4'd7, 32'h7FFF_FFFE);
        chk_irq(1'b0, "R7 preset rewrite clears irq");
        wr(4'd7, 32'h8000_0000);
        wr(4'd6, 32'h0000_0022);
        chk_irq(1'b0, "R7 interrupt enable off");
        rd(4'd6, 32'h0000_0022, "R2 last ctl readback");
        wr(4'd7, 32'hFFFF_FFFF);
        pulse(16'h0002);
        rd(4'd7, 32'h0, "R6 wrap to zero");
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            total++; fails++;
            $display("FAIL R10: %0d reads unanswered, expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule